// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block serves a load/store pipeline that supports two DSP addressing styles. For each request it produces the address to use for the access and the pointer value to write back. There are two circular-buffer modes, which differ only in where the increment comes from, and one bit-reversed mode suited to FFT data reordering.

A request is a single-cycle strobe carrying the current pointer, a modifier word, a circular start address, an access size and a mode. One cycle later the block presents the access address and the updated pointer together with a one-cycle valid flag. Both outputs hold their values until the next request. Memory access and data handling belong to other blocks.

In the circular modes the modifier word also carries the buffer length in its low bits and, for the register mode, a small signed increment. The bit-reversed mode adds the whole modifier word to the pointer.

Top module: `circ_brev_agen`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0 and `rsp_addr` and `rsp_ptr` are 0 until the first request.
- R2: `rsp_valid` is 1 in exactly the cycle after each cycle in which `req_valid` is 1, and 0 otherwise. Back-to-back requests give back-to-back valid cycles.
- R3: In cycles without a request, `rsp_addr` and `rsp_ptr` keep their values whatever the other inputs do.
- R4: Mode 0 is immediate circular. The access address is `ptr_in`. The new pointer is `ptr_in` plus the signed `imm_step`, kept inside [start, start+len), where start is `circ_start` and len is `modifier[16:0]`. A result equal to or above start+len has len subtracted.
- R5: In both circular modes, a result below `circ_start` has len added back. This also applies to negative increments.
- R6: Mode 1 is register circular. The increment is the signed 7-bit field `modifier[23:17]`, multiplied by the access size. `req_size` 0 means a byte (x1) and 1 means a halfword (x2). The address and wrap rules are those of R4 and R5.
- R7: In either circular mode, a len of 0 disables wrapping, and the pointer moves by the increment alone.
- R8: Modes 2 and 3 are bit-reversed. The access address keeps bits above 15 of `ptr_in` and replaces bits 15:0 with their mirror image, so that bit i moves to bit 15-i. `req_size` has no effect.
- R9: In the bit-reversed modes the new pointer is `ptr_in + modifier`, modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_mode | input | 2 | 0 immediate circular, 1 register circular, 2/3 bit-reversed |
| req_size | input | 1 | Access size: 0 byte, 1 halfword |
| ptr_in | input | ADDR_W | Current pointer |
| modifier | input | ADDR_W | Modifier word (length, register increment, or bit-reversed stride) |
| circ_start | input | ADDR_W | Circular buffer start address |
| imm_step | input | IMM_W | Signed immediate increment for mode 0 |
| rsp_valid | output | 1 | Result valid, one cycle after a request |
| rsp_addr | output | ADDR_W | Effective access address |
| rsp_ptr | output | ADDR_W | Post-modified pointer |

## Verification
The bench uses the default parameters, ADDR_W = 32 and IMM_W = 8. With a 32-bit address there are upper bits above the 16 reversed bits, so the bench can show that the bit-reversed mode leaves them alone, and it can check pointer wraparound at 2^32. With an 8-bit step the register increment of -64, doubled for a halfword, lands on the most negative step value of -128. That case, together with wraps exactly at start+len and just below start, covers the edges of the wrap logic.

// File: rtl/circ_brev_agen_pkg.sv
package circ_brev_agen_pkg;

  // Modifier word field layout for the circular modes
  localparam int CIRC_LEN_W   = 17;
  localparam int CIRC_INC_LSB = 17;
  localparam int CIRC_INC_W   = 7;

  // Number of low address bits mirrored in bit-reversed mode
  localparam int BREV_W = 16;

  typedef enum logic [1:0] {
    MODE_CIRC_IMM = 2'd0,
    MODE_CIRC_REG = 2'd1,
    MODE_BREV     = 2'd2,
    MODE_BREV_ALT = 2'd3
  } agen_mode_e;

endpackage

// File: rtl/agen_bit_reverse.sv
module agen_bit_reverse #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/agen_circ_step.sv
module agen_circ_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 17,
  parameter int STEP_W = 8
) (
  input  logic [ADDR_W-1:0]        base_ptr,
  input  logic [ADDR_W-1:0]        win_start,
  input  logic [LEN_W-1:0]         win_len,
  input  logic signed [STEP_W-1:0] step,
  output logic [ADDR_W-1:0]        next_ptr
);
  // Two guard bits: one for the carry above start+len, one for the sign
  localparam int EW = ADDR_W + 2;

  logic signed [EW-1:0] ptr_x;
  logic signed [EW-1:0] start_x;
  logic signed [EW-1:0] len_x;
  logic signed [EW-1:0] step_x;
  logic signed [EW-1:0] sum_x;
  logic signed [EW-1:0] limit_x;
  logic signed [EW-1:0] wrapped_x;

  assign ptr_x   = $signed({2'b00, base_ptr});
  assign start_x = $signed({2'b00, win_start});
  assign len_x   = $signed({{(EW-LEN_W){1'b0}}, win_len});
  assign step_x  = EW'(step);
  assign sum_x   = ptr_x + step_x;
  assign limit_x = start_x + len_x;

  always_comb begin
    wrapped_x = sum_x;
    if (win_len != '0) begin
      if (sum_x < start_x) begin
        wrapped_x = sum_x + len_x;
      end else if (sum_x >= limit_x) begin
        wrapped_x = sum_x - len_x;
      end
    end
  end

  assign next_ptr = wrapped_x[ADDR_W-1:0];
endmodule

// File: rtl/circ_brev_agen.sv
module circ_brev_agen
  import circ_brev_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic [ADDR_W-1:0] modifier,
  input  logic [ADDR_W-1:0] circ_start,
  input  logic [IMM_W-1:0]  imm_step,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_ptr
);
  // Step wide enough for the immediate and for the doubled register field
  localparam int REG_STEP_W = CIRC_INC_W + 1;
  localparam int STEP_W     = (IMM_W > REG_STEP_W) ? IMM_W : REG_STEP_W;

  agen_mode_e mode;
  assign mode = agen_mode_e'(req_mode);

  // Circular operand extraction
  logic [CIRC_LEN_W-1:0]        circ_len;
  logic signed [CIRC_INC_W-1:0] reg_inc;
  logic signed [IMM_W-1:0]      imm_s;
  logic signed [STEP_W-1:0]     imm_ext;
  logic signed [STEP_W-1:0]     reg_ext;
  logic signed [STEP_W-1:0]     step_sel;
  logic [ADDR_W-1:0]            circ_next;

  assign circ_len = modifier[CIRC_LEN_W-1:0];
  assign reg_inc  = modifier[CIRC_INC_LSB +: CIRC_INC_W];
  assign imm_s    = imm_step;
  assign imm_ext  = STEP_W'(imm_s);
  assign reg_ext  = STEP_W'(reg_inc) <<< req_size;
  assign step_sel = (mode == MODE_CIRC_REG) ? reg_ext : imm_ext;

  agen_circ_step #(
    .ADDR_W (ADDR_W),
    .LEN_W  (CIRC_LEN_W),
    .STEP_W (STEP_W)
  ) u_circ_step (
    .base_ptr  (ptr_in),
    .win_start (circ_start),
    .win_len   (circ_len),
    .step      (step_sel),
    .next_ptr  (circ_next)
  );

  // Bit-reversed path
  logic [BREV_W-1:0] low_mirror;
  logic [ADDR_W-1:0] brev_addr;
  logic [ADDR_W-1:0] brev_next;

  agen_bit_reverse #(
    .W (BREV_W)
  ) u_bit_reverse (
    .din  (ptr_in[BREV_W-1:0]),
    .dout (low_mirror)
  );

  assign brev_addr = {ptr_in[ADDR_W-1:BREV_W], low_mirror};
  assign brev_next = ptr_in + modifier;

  // Next-state logic
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    valid_d = req_valid;
    addr_d  = addr_q;
    ptr_d   = ptr_q;
    if (req_valid) begin
      unique case (mode)
        MODE_CIRC_IMM, MODE_CIRC_REG: begin
          addr_d = ptr_in;
          ptr_d  = circ_next;
        end
        MODE_BREV, MODE_BREV_ALT: begin
          addr_d = brev_addr;
          ptr_d  = brev_next;
        end
        default: begin
          addr_d = addr_q;
          ptr_d  = ptr_q;
        end
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (req_valid) begin
        addr_q <= addr_d;
        ptr_q  <= ptr_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_addr  = addr_q;
  assign rsp_ptr   = ptr_q;
endmodule

// File: rtl/circ_brev_agen_chk.sv
module circ_brev_agen_chk
  import circ_brev_agen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_mode,
  input logic              req_size,
  input logic [ADDR_W-1:0] ptr_in,
  input logic [ADDR_W-1:0] modifier,
  input logic [ADDR_W-1:0] circ_start,
  input logic [IMM_W-1:0]  imm_step,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [ADDR_W-1:0] rsp_ptr
);
  localparam int XW = ADDR_W + 1;

  logic [XW-1:0]        len_x;
  logic [XW-1:0]        start_x;
  logic [XW-1:0]        ptr_x;
  logic [XW-1:0]        out_x;
  logic signed [IMM_W-1:0] imm_s;
  logic signed [XW-1:0] imm_x;
  logic [XW-1:0]        imm_mag;
  logic                 ptr_in_window;
  logic                 step_short;

  assign len_x   = XW'(modifier[CIRC_LEN_W-1:0]);
  assign start_x = {1'b0, circ_start};
  assign ptr_x   = {1'b0, ptr_in};
  assign out_x   = {1'b0, rsp_ptr};
  assign imm_s   = imm_step;
  assign imm_x   = XW'(imm_s);
  assign imm_mag = imm_s[IMM_W-1] ? XW'(-imm_x) : XW'(imm_x);
  assign ptr_in_window = (len_x != '0) && (ptr_x >= start_x) && (ptr_x < start_x + len_x);
  assign step_short    = imm_mag < len_x;

  // R2: valid follows a request by one cycle
  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2: no request, no valid
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3: outputs hold while idle
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_ptr)));

  // R4: circular access uses the incoming pointer
  a_r4_circ_addr_is_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1] == 1'b0) |=> (rsp_addr == $past(ptr_in)));

  // R4: a pointer inside the window with a short step stays inside
  a_r4_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MODE_CIRC_IMM && ptr_in_window && step_short)
    |=> ((out_x >= $past(start_x)) && (out_x < $past(start_x) + $past(len_x))));

  // R8: bit-reversed access keeps the upper pointer bits
  a_r8_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1]) |=> (rsp_addr[ADDR_W-1:BREV_W] == $past(ptr_in[ADDR_W-1:BREV_W])));

  // R9: bit-reversed pointer advances by the modifier
  a_r9_brev_post_add: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1]) |=> (rsp_ptr == $past(ptr_in) + $past(modifier)));
endmodule

bind circ_brev_agen circ_brev_agen_chk #(
  .ADDR_W (ADDR_W),
  .IMM_W  (IMM_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mode   (req_mode),
  .req_size   (req_size),
  .ptr_in     (ptr_in),
  .modifier   (modifier),
  .circ_start (circ_start),
  .imm_step   (imm_step),
  .rsp_valid  (rsp_valid),
  .rsp_addr   (rsp_addr),
  .rsp_ptr    (rsp_ptr)
);

// File: tb/circ_brev_agen_test.sv
module circ_brev_agen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic        req_size;
  logic [31:0] ptr_in;
  logic [31:0] modifier;
  logic [31:0] circ_start;
  logic [7:0]  imm_step;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [31:0] rsp_ptr;

  int checks;
  int fails;

  circ_brev_agen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_size   (req_size),
    .ptr_in     (ptr_in),
    .modifier   (modifier),
    .circ_start (circ_start),
    .imm_step   (imm_step),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_ptr    (rsp_ptr)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one request; returns at the falling edge after the capturing edge
  task automatic issue(input logic [1:0] m, input logic sz, input logic [31:0] p,
                       input logic [31:0] mdf, input logic [31:0] st, input logic [7:0] im);
    @(negedge clk);
    req_valid  = 1'b1;
    req_mode   = m;
    req_size   = sz;
    ptr_in     = p;
    modifier   = mdf;
    circ_start = st;
    imm_step   = im;
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [31:0] ea, input logic [31:0] ep);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " addr"}, rsp_addr, ea);
    chk({tag, " ptr"}, rsp_ptr, ep);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_mode = '0; req_size = 1'b0;
    ptr_in = '0; modifier = '0; circ_start = '0; imm_step = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1 addr in reset", rsp_addr, 32'd0);
    chk("R1 ptr in reset", rsp_ptr, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 ptr after reset", rsp_ptr, 32'd0);
  endtask

  task automatic t_imm_circ();
    logic [31:0] p;
    logic [31:0] exp_p [4];
    exp_p[0] = 32'h1001; exp_p[1] = 32'h1000; exp_p[2] = 32'h1001; exp_p[3] = 32'h1000;
    p = 32'h1000;
    for (int i = 0; i < 4; i++) begin
      issue(2'd0, 1'b0, p, 32'd2, 32'h1000, 8'd1);
      expect_rsp("R4 imm circ len2", p, exp_p[i]);
      p = rsp_ptr;
    end
    // exactly reaching start+len wraps to start
    issue(2'd0, 1'b0, 32'h4006, 32'd8, 32'h4000, 8'd2);
    expect_rsp("R4 wrap at limit", 32'h4006, 32'h4000);
    issue(2'd0, 1'b0, 32'h4007, 32'd8, 32'h4000, 8'd3);
    expect_rsp("R4 wrap past limit", 32'h4007, 32'h4002);
  endtask

  task automatic t_reg_circ();
    logic [31:0] p;
    logic [31:0] exp_p [4];
    exp_p[0] = 32'h8002; exp_p[1] = 32'h8000; exp_p[2] = 32'h8002; exp_p[3] = 32'h8000;
    p = 32'h8000;
    for (int i = 0; i < 4; i++) begin
      issue(2'd1, 1'b1, p, (32'd1 << 17) | 32'd4, 32'h8000, 8'd0);
      expect_rsp("R6 reg circ halfword", p, exp_p[i]);
      p = rsp_ptr;
    end
    issue(2'd1, 1'b0, 32'h8000, (32'd1 << 17) | 32'd2, 32'h8000, 8'd0);
    expect_rsp("R6 reg circ byte", 32'h8000, 32'h8001);
  endtask

  task automatic t_neg_wrap();
    issue(2'd0, 1'b0, 32'h2002, 32'd16, 32'h2000, 8'hFB);
    expect_rsp("R5 imm below start", 32'h2002, 32'h200D);
    // field -64 doubled gives -128
    issue(2'd1, 1'b1, 32'h3010, 32'h0080_0100, 32'h3000, 8'd0);
    expect_rsp("R5 R6 reg -128", 32'h3010, 32'h3090);
    issue(2'd1, 1'b0, 32'h3010, 32'h0080_0100, 32'h3000, 8'd0);
    expect_rsp("R5 R6 reg -64", 32'h3010, 32'h30D0);
  endtask

  task automatic t_len_zero();
    issue(2'd0, 1'b0, 32'h5000, 32'd0, 32'h5000, 8'd100);
    expect_rsp("R7 len0 forward", 32'h5000, 32'h5064);
    issue(2'd0, 1'b0, 32'h5000, 32'd0, 32'h5000, 8'hFD);
    expect_rsp("R7 len0 backward", 32'h5000, 32'h4FFD);
    issue(2'd1, 1'b1, 32'h5000, 32'd5 << 17, 32'h5000, 8'd0);
    expect_rsp("R7 len0 reg", 32'h5000, 32'h500A);
  endtask

  task automatic t_brev();
    logic [31:0] p;
    logic [31:0] exp_a [4];
    exp_a[0] = 32'hABCD0000; exp_a[1] = 32'hABCD0004;
    exp_a[2] = 32'hABCD0002; exp_a[3] = 32'hABCD0006;
    p = 32'hABCD0000;
    for (int i = 0; i < 4; i++) begin
      issue(2'd2, 1'b0, p, 32'h2000, 32'h0, 8'd0);
      expect_rsp("R8 R9 brev sequence", exp_a[i], p + 32'h2000);
      p = rsp_ptr;
    end
    issue(2'd3, 1'b0, 32'h12340001, 32'h10, 32'h0, 8'd0);
    expect_rsp("R8 mode3 brev", 32'h12348000, 32'h12340011);
    issue(2'd2, 1'b1, 32'h00010003, 32'd4, 32'h0, 8'd0);
    expect_rsp("R8 size ignored", 32'h0001C000, 32'h00010007);
    issue(2'd2, 1'b0, 32'hFFFFFFFF, 32'd1, 32'h0, 8'd0);
    expect_rsp("R9 ptr wraps", 32'hFFFFFFFF, 32'h00000000);
  endtask

  task automatic t_hold();
    issue(2'd0, 1'b0, 32'h1000, 32'd2, 32'h1000, 8'd1);
    ptr_in = 32'hDEAD0000; modifier = 32'h1234; circ_start = 32'h77; imm_step = 8'h55;
    req_mode = 2'd2;
    repeat (3) @(negedge clk);
    chk("R2 valid drops when idle", 32'(rsp_valid), 32'd0);
    chk("R3 addr held", rsp_addr, 32'h1000);
    chk("R3 ptr held", rsp_ptr, 32'h1001);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd0; req_size = 1'b0;
    ptr_in = 32'h6000; modifier = 32'd64; circ_start = 32'h6000; imm_step = 8'd4;
    @(negedge clk);
    expect_rsp("R2 first of pair", 32'h6000, 32'h6004);
    req_mode = 2'd2; ptr_in = 32'h00000001; modifier = 32'd2;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R2 second of pair", 32'h00008000, 32'h00000003);
    @(negedge clk);
    chk("R2 valid low after pair", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    t_reset();
    t_imm_circ();
    t_reg_circ();
    t_neg_wrap();
    t_len_zero();
    t_brev();
    t_hold();
    t_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule